// File: doc/BRIEF.md
# CAN Transmit Request Controller

This block is the host-facing half of transmission in a CAN controller. The host loads a frame into a 13-byte transmit buffer over a small register bus. It then writes a command byte that asks for a transmission, asks for a transmission that is also received by this node, or aborts a pending frame. Toward the bit-stream engine the block presents a pending request with two qualifiers. The first asks for a single attempt with no retry. The second asks for self reception. The engine answers with start, success, error and arbitration-lost events, and the block keeps the buffer-lock, transmit-busy and transmission-complete status.

A transmit interrupt pulse marks every return of the buffer to the released state. This covers a successful send, an abort, and a single-shot attempt that failed. The engine reads buffer bytes through a plain index/data port. No data flows in a stream here, so the block has no valid/ready handshake. Every pin is a plain level or a one-cycle event, and the engine is trusted to raise start only while a request is shown.

The command register sits at address 0. Its bit 0 is the transmit request, bit 1 is the abort and bit 2 is the self-reception request. The buffer bytes 0 to 12 sit at addresses 16 to 28.

Top module: `can_txreq_ctrl`

## Requirements
- R1: After rst_n is released the outputs are buf_released=1, tx_busy=0, tx_complete=1, tx_irq=0, eng_req=0, eng_single_shot=0 and eng_self_rx=0, and every buffer byte holds 0x00.
- R2: In operating mode (reset_mode=0) with the buffer released, a host write to address 16+k (k=0..12) stores the byte. host_rdata at that address returns it in the same cycle, and eng_rd_data returns it for eng_rd_idx=k. Unmapped addresses read 0x00.
- R3: While reset_mode=1, buffer addresses read 0xFF, buffer writes and commands are ignored, and one cycle later the state is released, idle and complete, with no request and no interrupt.
- R4: A host write to the buffer while it is locked (buf_released=0) leaves the buffer contents unchanged and flags nothing.
- R5: A command write to address 0 with bit 0 or bit 2 set, while the buffer is released, raises eng_req, locks the buffer and clears tx_complete one cycle later. Such a command while the buffer is locked is ignored. Address 0 always reads 0x00.
- R6: Request+abort (0x03) gives eng_single_shot=1 and eng_self_rx=0. Self-reception+abort (0x06) gives eng_single_shot=1 and eng_self_rx=1. All three bits (0x07) behave like 0x03.
- R7: When request and self-reception are set together (0x05), eng_self_rx stays 0. Self-reception alone (0x04) gives eng_self_rx=1.
- R8: eng_start while eng_req is high clears eng_req and sets tx_busy one cycle later. A command write of 0x00 does not cancel a pending request.
- R9: An abort (0x02) while a request is pending and not started drops the request and releases the buffer. During tx_busy the abort does not stop the frame. The frame then ends released either way: on success tx_complete=1, and on error or lost arbitration there is no retry and tx_complete=0.
- R10: Without single-shot or an abort, an eng_err or eng_arb_lost during tx_busy raises eng_req again and keeps the buffer locked.
- R11: tx_irq is a one-cycle pulse, raised in the cycle after the buffer becomes released, and only then.
- R12: eng_done_ok during tx_busy sets tx_complete and releases the buffer one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reset_mode | input | 1 | Controller held in reset mode |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 5 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational on host_addr) |
| eng_req | output | 1 | Frame pending for the bit-stream engine |
| eng_single_shot | output | 1 | Attempt once, no retry |
| eng_self_rx | output | 1 | Frame is also received by this node |
| eng_rd_idx | input | 4 | Engine buffer byte index |
| eng_rd_data | output | 8 | Engine buffer byte |
| eng_start | input | 1 | Engine has started the frame |
| eng_done_ok | input | 1 | Frame sent successfully |
| eng_err | input | 1 | Frame ended by a bus error |
| eng_arb_lost | input | 1 | Frame ended by lost arbitration |
| buf_released | output | 1 | 1 = buffer writable, 0 = locked |
| tx_busy | output | 1 | Frame on the bus |
| tx_complete | output | 1 | Last requested frame sent successfully |
| tx_irq | output | 1 | Transmit interrupt pulse |

## Verification
Every status output and engine qualifier settles one clock after the edge that samples the command write or engine event. Buffer and command reads are combinational on the address. The bench drives inputs on the falling edge, and a behavioural model advances on the rising edge. All registered outputs are compared with the model at each falling edge, which is half a cycle after they update. Reads are checked a short delay after the address is driven. The scripted checks for each command combination look at the first falling edge after the write, so tx_irq is caught in the single cycle it is high.

// File: rtl/can_txreq_pkg.sv
package can_txreq_pkg;
  localparam int CMD_REQ_BIT   = 0;
  localparam int CMD_ABORT_BIT = 1;
  localparam int CMD_SELF_BIT  = 2;

  typedef struct packed {
    logic req;
    logic abort;
    logic self_rx;
  } txcmd_t;

  function automatic txcmd_t decode_cmd(input logic [7:0] d);
    txcmd_t c;
    c.req     = d[CMD_REQ_BIT];
    c.abort   = d[CMD_ABORT_BIT];
    c.self_rx = d[CMD_SELF_BIT];
    return c;
  endfunction
endpackage

// File: rtl/can_txreq_buf.sv
module can_txreq_buf #(
  parameter int BYTES  = 13,
  parameter int ADDR_W = 5,
  parameter int BASE   = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_mode,
  input  logic              locked,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              hit,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [IDX_W-1:0]  eng_rd_idx,
  output logic [DATA_W-1:0] eng_rd_data
);
  localparam int LAST = BASE + BYTES - 1;

  logic [BYTES-1:0][DATA_W-1:0] mem;
  logic [ADDR_W-1:0]            offs;
  logic [IDX_W-1:0]             idx;
  logic                         wr_ok;

  assign hit   = (int'(host_addr) >= BASE) && (int'(host_addr) <= LAST);
  assign offs  = host_addr - ADDR_W'(BASE);
  assign idx   = offs[IDX_W-1:0];
  assign wr_ok = host_we && hit && !reset_mode && !locked;

  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (wr_ok && (int'(idx) == g))
        mem[g] <= host_wdata;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (hit) host_rdata = reset_mode ? '1 : mem[idx];
  end

  always_comb begin
    eng_rd_data = '0;
    if (int'(eng_rd_idx) < BYTES) eng_rd_data = mem[eng_rd_idx];
  end

  AST_LOCKED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && hit && locked) |=> $stable(mem)); // R4
  AST_RESET_MODE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_mode && host_we) |=> $stable(mem)); // R3
endmodule

// File: rtl/can_txreq_seq.sv
module can_txreq_seq
  import can_txreq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   reset_mode,
  input  logic   cmd_wr,
  input  txcmd_t cmd,
  input  logic   eng_start,
  input  logic   eng_done_ok,
  input  logic   eng_err,
  input  logic   eng_arb_lost,
  output logic   pend,
  output logic   single_shot,
  output logic   self_rx,
  output logic   busy,
  output logic   locked,
  output logic   complete,
  output logic   irq
);
  logic abort_hold;
  logic fail_ev;
  logic no_retry;
  logic new_req;
  logic pure_abort;

  assign fail_ev    = eng_err || eng_arb_lost;
  assign no_retry   = single_shot || abort_hold;
  assign new_req    = cmd_wr && (cmd.req || cmd.self_rx) && !locked;
  assign pure_abort = cmd_wr && cmd.abort && !cmd.req && !cmd.self_rx;

  always_ff @(posedge clk) begin
    if (!rst_n || reset_mode) begin
      pend        <= 1'b0;
      busy        <= 1'b0;
      locked      <= 1'b0;
      single_shot <= 1'b0;
      self_rx     <= 1'b0;
      abort_hold  <= 1'b0;
      complete    <= 1'b1;
      irq         <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (eng_start && pend) begin
        pend <= 1'b0;
        busy <= 1'b1;
      end else if (eng_done_ok && busy) begin
        busy       <= 1'b0;
        locked     <= 1'b0;
        complete   <= 1'b1;
        abort_hold <= 1'b0;
        irq        <= 1'b1;
      end else if (fail_ev && busy) begin
        busy <= 1'b0;
        if (no_retry) begin
          locked     <= 1'b0;
          abort_hold <= 1'b0;
          irq        <= 1'b1;
        end else begin
          pend <= 1'b1;
        end
      end else if (new_req) begin
        pend        <= 1'b1;
        locked      <= 1'b1;
        complete    <= 1'b0;
        single_shot <= cmd.abort;
        self_rx     <= cmd.self_rx && !cmd.req;
        abort_hold  <= 1'b0;
      end else if (pure_abort) begin
        if (pend) begin
          pend   <= 1'b0;
          locked <= 1'b0;
          irq    <= 1'b1;
        end else if (busy) begin
          abort_hold <= 1'b1;
        end
      end
    end
  end

  AST_BUSY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || pend) |-> locked); // R5
  AST_START_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && pend && !reset_mode) |=> (busy && !pend)); // R8
  AST_ZERO_NO_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && cmd_wr && cmd == '0 && !eng_start && !reset_mode) |=> pend); // R8
  AST_OK_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done_ok && !reset_mode) |=> (complete && !locked)); // R12
  AST_RETRY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fail_ev && !no_retry && !reset_mode) |=> (pend && locked)); // R10
  AST_IRQ_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!locked && $past(locked))); // R11
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R11
  AST_RESET_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_mode |=> (!locked && !busy && !pend && complete && !irq)); // R3
endmodule

// File: rtl/can_txreq_ctrl.sv
module can_txreq_ctrl
  import can_txreq_pkg::*;
#(
  parameter int BUF_BYTES = 13,
  parameter int ADDR_W    = 5,
  parameter int BUF_BASE  = 16,
  parameter int CMD_ADDR  = 0,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_mode,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              eng_req,
  output logic              eng_single_shot,
  output logic              eng_self_rx,
  input  logic [IDX_W-1:0]  eng_rd_idx,
  output logic [DATA_W-1:0] eng_rd_data,
  input  logic              eng_start,
  input  logic              eng_done_ok,
  input  logic              eng_err,
  input  logic              eng_arb_lost,
  output logic              buf_released,
  output logic              tx_busy,
  output logic              tx_complete,
  output logic              tx_irq
);
  logic              locked;
  logic              buf_hit;
  logic [DATA_W-1:0] buf_rdata;
  logic              cmd_wr;
  txcmd_t            cmd;

  assign cmd_wr = host_we && (host_addr == ADDR_W'(CMD_ADDR)) && !reset_mode;
  assign cmd    = decode_cmd(host_wdata[7:0]);

  can_txreq_buf #(
    .BYTES(BUF_BYTES), .ADDR_W(ADDR_W), .BASE(BUF_BASE),
    .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode), .locked(locked),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .hit(buf_hit), .host_rdata(buf_rdata),
    .eng_rd_idx(eng_rd_idx), .eng_rd_data(eng_rd_data)
  );

  can_txreq_seq u_seq (
    .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode),
    .cmd_wr(cmd_wr), .cmd(cmd),
    .eng_start(eng_start), .eng_done_ok(eng_done_ok),
    .eng_err(eng_err), .eng_arb_lost(eng_arb_lost),
    .pend(eng_req), .single_shot(eng_single_shot), .self_rx(eng_self_rx),
    .busy(tx_busy), .locked(locked), .complete(tx_complete), .irq(tx_irq)
  );

  assign host_rdata   = buf_hit ? buf_rdata : '0;
  assign buf_released = !locked;

  AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == ADDR_W'(CMD_ADDR)) |-> (host_rdata == '0)); // R5
endmodule

// File: tb/can_txreq_ctrl_bench.sv
module can_txreq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reset_mode = 1'b0;
  logic       host_we = 1'b0;
  logic [4:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       eng_req, eng_single_shot, eng_self_rx;
  logic [3:0] eng_rd_idx = '0;
  logic [7:0] eng_rd_data;
  logic       eng_start = 0, eng_done_ok = 0, eng_err = 0, eng_arb_lost = 0;
  logic       buf_released, tx_busy, tx_complete, tx_irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  can_txreq_ctrl u_can_txreq_ctrl (
    .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .eng_req(eng_req),
    .eng_single_shot(eng_single_shot), .eng_self_rx(eng_self_rx),
    .eng_rd_idx(eng_rd_idx), .eng_rd_data(eng_rd_data),
    .eng_start(eng_start), .eng_done_ok(eng_done_ok), .eng_err(eng_err),
    .eng_arb_lost(eng_arb_lost), .buf_released(buf_released),
    .tx_busy(tx_busy), .tx_complete(tx_complete), .tx_irq(tx_irq)
  );

  // behavioural reference
  bit m_pend, m_busy, m_lock, m_ss, m_srx, m_abf, m_comp, m_irq;
  byte unsigned m_mem [13];

  always @(posedge clk) begin
    bit lock_before;
    lock_before = m_lock;
    if (!rst_n) begin
      m_pend = 0; m_busy = 0; m_lock = 0; m_ss = 0; m_srx = 0;
      m_abf = 0; m_comp = 1; m_irq = 0;
      foreach (m_mem[i]) m_mem[i] = 8'h00;
    end else if (reset_mode) begin
      m_pend = 0; m_busy = 0; m_lock = 0; m_ss = 0; m_srx = 0;
      m_abf = 0; m_comp = 1; m_irq = 0;
    end else begin
      if (host_we && host_addr >= 16 && host_addr <= 28 && !lock_before)
        m_mem[host_addr - 16] = host_wdata;
      m_irq = 0;
      if (eng_start && m_pend) begin
        m_pend = 0; m_busy = 1;
      end else if (eng_done_ok && m_busy) begin
        m_busy = 0; m_lock = 0; m_comp = 1; m_irq = 1; m_abf = 0;
      end else if ((eng_err || eng_arb_lost) && m_busy) begin
        m_busy = 0;
        if (m_ss || m_abf) begin m_lock = 0; m_irq = 1; m_abf = 0; end
        else m_pend = 1;
      end else if (host_we && host_addr == 0) begin
        bit r, a, s;
        r = host_wdata[0]; a = host_wdata[1]; s = host_wdata[2];
        if ((r || s) && !m_lock) begin
          m_pend = 1; m_lock = 1; m_comp = 0; m_ss = a; m_srx = s && !r; m_abf = 0;
        end else if (a && !r && !s) begin
          if (m_pend) begin m_pend = 0; m_lock = 0; m_irq = 1; end
          else if (m_busy) m_abf = 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(buf_released == !m_lock, "R4 buf_released vs model", buf_released, !m_lock);
      chk(tx_busy == m_busy, "R8 tx_busy vs model", tx_busy, m_busy);
      chk(tx_complete == m_comp, "R12 tx_complete vs model", tx_complete, m_comp);
      chk(tx_irq == m_irq, "R11 tx_irq vs model", tx_irq, m_irq);
      chk(eng_req == m_pend, "R5 eng_req vs model", eng_req, m_pend);
      chk(eng_single_shot == m_ss, "R6 single_shot vs model", eng_single_shot, m_ss);
      chk(eng_self_rx == m_srx, "R7 self_rx vs model", eng_self_rx, m_srx);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic ev(input int kind);
    @(negedge clk);
    case (kind)
      0: eng_start = 1;
      1: eng_done_ok = 1;
      2: eng_err = 1;
      default: eng_arb_lost = 1;
    endcase
    @(negedge clk);
    eng_start = 0; eng_done_ok = 0; eng_err = 0; eng_arb_lost = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    host_addr = a;
    #1;
    chk(host_rdata == exp, tag, host_rdata, exp);
  endtask

  task automatic st(input bit rel, input bit busy, input bit comp, input bit req,
                    input bit irq, input string tag);
    chk({buf_released, tx_busy, tx_complete, eng_req, tx_irq} ==
        {rel, busy, comp, req, irq}, tag,
        {buf_released, tx_busy, tx_complete, eng_req, tx_irq},
        {rel, busy, comp, req, irq});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    st(1, 0, 1, 0, 0, "R1 reset state");
    rd(16, 8'h00, "R1 buffer cleared");

    // R3: reset mode
    reset_mode = 1;
    wr(16, 8'h55);
    rd(16, 8'hFF, "R3 reads FF in reset mode");
    wr(0, 8'h01);
    st(1, 0, 1, 0, 0, "R3 command ignored in reset mode");
    reset_mode = 0;
    rd(16, 8'h00, "R3 write in reset mode dropped");

    // R2: fill and read back
    for (int i = 0; i < 13; i++) wr(5'(16 + i), 8'(i * 17 + 3));
    for (int i = 0; i < 13; i++) rd(5'(16 + i), 8'(i * 17 + 3), "R2 host readback");
    rd(29, 8'h00, "R2 unmapped reads zero");
    for (int i = 0; i < 13; i += 4) begin
      @(negedge clk); eng_rd_idx = 4'(i); #1;
      chk(eng_rd_data == 8'(i * 17 + 3), "R2 engine read", eng_rd_data, i * 17 + 3);
    end

    // R5/R4/R8/R10/R11/R12
    wr(0, 8'h01);
    st(0, 0, 0, 1, 0, "R5 request locks and clears complete");
    rd(0, 8'h00, "R5 command reads zero");
    wr(16, 8'hAA);
    rd(16, 8'h03, "R4 locked write dropped");
    wr(0, 8'h00);
    st(0, 0, 0, 1, 0, "R8 writing zero keeps request");
    ev(0);
    st(0, 1, 0, 0, 0, "R8 start clears request");
    ev(2);
    st(0, 0, 0, 1, 0, "R10 error retries");
    ev(0);
    ev(3);
    st(0, 0, 0, 1, 0, "R10 arbitration loss retries");
    ev(0);
    ev(1);
    st(1, 0, 1, 0, 1, "R12 success completes, R11 irq");
    @(negedge clk);
    chk(tx_irq == 0, "R11 irq single cycle", tx_irq, 0);

    // R6 single shot
    wr(0, 8'h03);
    chk({eng_single_shot, eng_self_rx} == 2'b10, "R6 req+abort", {eng_single_shot, eng_self_rx}, 2'b10);
    ev(0); ev(2);
    st(1, 0, 0, 0, 1, "R6 single shot no retry");
    wr(0, 8'h06);
    chk({eng_single_shot, eng_self_rx} == 2'b11, "R6 self+abort", {eng_single_shot, eng_self_rx}, 2'b11);
    ev(0); ev(1);
    wr(0, 8'h07);
    chk({eng_single_shot, eng_self_rx} == 2'b10, "R6 all three", {eng_single_shot, eng_self_rx}, 2'b10);
    ev(0); ev(1);

    // R7 and R9 abort before start
    wr(0, 8'h05);
    chk({eng_single_shot, eng_self_rx} == 2'b00, "R7 self ignored with req", {eng_single_shot, eng_self_rx}, 2'b00);
    wr(0, 8'h02);
    st(1, 0, 0, 0, 1, "R9 abort before start");
    wr(0, 8'h04);
    chk({eng_single_shot, eng_self_rx} == 2'b01, "R7 self alone", {eng_single_shot, eng_self_rx}, 2'b01);

    // R9 abort during frame, then error
    ev(0);
    wr(0, 8'h02);
    st(0, 1, 0, 0, 0, "R9 abort does not stop frame");
    ev(2);
    st(1, 0, 0, 0, 1, "R9 aborted frame no retry");

    // R9 abort during frame, then success
    wr(0, 8'h01); ev(0); wr(0, 8'h02); ev(1);
    st(1, 0, 1, 0, 1, "R9 aborted frame completes on success");

    // R3 reset mode while locked
    wr(0, 8'h01);
    reset_mode = 1;
    @(negedge clk);
    st(1, 0, 1, 0, 0, "R3 reset mode releases");
    reset_mode = 0;
    repeat (2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule